// File: doc/BRIEF.md
# Byte-Channel Host Command Interface

This block is the device side of a two-address host I/O window. Address 0 is a byte-wide data port used in both directions. Address 1 returns a status byte on reads and takes a command byte on writes. The host opens a request with a start command and streams request bytes, one at a time, through a one-byte input buffer. It closes the request with an end command, then reads back a framed response one byte at a time through a one-byte output buffer. Each step is paced by the status flags.

Behind the window, a plain valid/ready channel hands each request byte to a backend, with one-cycle pulses when a request ends or is aborted. A second valid/ready channel takes response bytes from the backend. The block wraps those bytes between a head marker and a tail marker. Each marker is flagged by a separate status bit, so the host can tell framing bytes from payload bytes. A short response is padded with zero bytes up to a minimum length. An abort command returns the block to the idle, ready state from any phase.

Top module: `hci_host_port`

## Requirements
- R1: After reset the status byte reads 0x10. The status bit positions are: bit0 output full, bit1 input full, bit2 marker flag, bit3 last write went to the command address, bit4 ready for command, bit5 ready for data, bit6 always 0, bit7 sticky overrun.
- R2: In the ready state, writing 0x01 to address 1 starts a request. Ready-for-data (bit5) is set and ready-for-command (bit4) is cleared at the next clock.
- R3: During a request, a data write sets input full and presents the byte on `req_data` with `req_valid`. Input full clears on the clock where the backend takes the byte with `req_ready`.
- R4: A data write while input full is set is dropped. The held byte is unchanged, and bit7 is set and stays set until an abort.
- R5: Data writes outside a request are ignored: input full and `req_valid` stay low and bit5 stays low.
- R6: Writing 0x03 to address 1 during a request with input full clear ends the request. Bit5 drops and `req_end` pulses for one cycle. The same write while input full is set is ignored.
- R7: After the request ends, the first response byte offered by the backend causes the head marker 0x01 to appear on address 0, with status bits 0 and 2 set. Bit0 signals that the request has completed.
- R8: Each payload byte appears on address 0 with bit0 set and bit2 clear. A host read of address 0 clears bit0, and the next byte is taken from the backend only after that.
- R9: After the last payload byte has been read, the tail marker 0x03 appears with bits 0 and 2 set. Reading it returns the block to the ready state.
- R10: A response shorter than `MIN_RSP_BYTES` (default 6) is extended with 0x00 bytes to that length before the tail marker.
- R11: Writing 0x22 to address 1 in any phase makes the status exactly 0x10 at the next clock. It pulses `req_abort`, drops held bytes, and takes no response byte.
- R12: Bit3 is set by any command write and cleared by any data write.
- R13: Command codes other than 0x01, 0x03 and 0x22 are ignored. A start command outside the ready state and an end command outside a request are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_addr | input | 1 | 0 = data port, 1 = status/command port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status (address 1) or output buffer (address 0) |
| req_valid | output | 1 | A request byte is held for the backend |
| req_ready | input | 1 | Backend takes the held request byte |
| req_data | output | 8 | Held request byte |
| req_end | output | 1 | One-cycle pulse: request closed |
| req_abort | output | 1 | One-cycle pulse: abort command seen |
| rsp_valid | input | 1 | Backend offers a response byte |
| rsp_ready | output | 1 | Block takes the offered response byte |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Offered byte is the last payload byte |

## Verification
A wrong phase shows at address 1 on the very next clock, because bits 4 and 5 are decoded straight from the phase, and every host write is followed by a status read. A corrupted output buffer or marker flag shows on the first host read after the fault: the sweep compares every framed byte, and its marker bit, against a value computed from the request and response lengths. A lost handshake shows within a few cycles as a flag that fails to clear or a byte repeated or skipped. Pad and tail faults show when the byte count differs from the maximum of the payload length and six.

// File: rtl/hci_pkg.sv
package hci_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CODE_START = 8'h01;
    localparam byte_t CODE_END   = 8'h03;
    localparam byte_t CODE_ABORT = 8'h22;
    localparam byte_t MARK_HEAD  = 8'h01;
    localparam byte_t MARK_TAIL  = 8'h03;
    localparam byte_t PAD_BYTE   = 8'h00;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_WAIT,
        PH_SEND,
        PH_TAIL
    } phase_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_START,
        CMD_END,
        CMD_ABORT
    } cmd_e;

    // Bit order is visible to the host: obf is bit 0, ovr is bit 7.
    typedef struct packed {
        logic ovr;
        logic rsvd;
        logic ibr;
        logic rdy;
        logic a2;
        logic f0;
        logic ibf;
        logic obf;
    } status_t;

    typedef struct packed {
        logic  wr_cmd;
        logic  wr_data;
        logic  rd_data;
        byte_t wdata;
    } host_op_t;

    function automatic cmd_e decode_cmd(input byte_t code);
        case (code)
            CODE_START: return CMD_START;
            CODE_END:   return CMD_END;
            CODE_ABORT: return CMD_ABORT;
            default:    return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hci_phase_ctrl.sv
module hci_phase_ctrl
    import hci_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_op_t op,
    input  logic     ibf,
    input  logic     obf,
    input  logic     rsp_valid,
    input  logic     tail_set,
    output phase_e   phase,
    output logic     a2,
    output logic     cancel,
    output logic     req_end,
    output logic     req_abort
);

    cmd_e   cmd;
    phase_e phase_nx;
    logic   end_fire;

    always_comb begin
        cmd    = op.wr_cmd ? decode_cmd(op.wdata) : CMD_NONE;
        cancel = (cmd == CMD_ABORT);
    end

    always_comb begin
        phase_nx = phase;
        end_fire = 1'b0;
        unique case (phase)
            PH_IDLE: if (cmd == CMD_START) phase_nx = PH_RECV;
            PH_RECV: if (cmd == CMD_END && !ibf) begin
                phase_nx = PH_WAIT;
                end_fire = 1'b1;
            end
            PH_WAIT: if (rsp_valid) phase_nx = PH_SEND;
            PH_SEND: if (tail_set) phase_nx = PH_TAIL;
            PH_TAIL: if (op.rd_data && obf) phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
        if (cancel) begin
            phase_nx = PH_IDLE;
            end_fire = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            a2        <= 1'b0;
            req_end   <= 1'b0;
            req_abort <= 1'b0;
        end else begin
            phase     <= phase_nx;
            req_end   <= end_fire;
            req_abort <= cancel;
            if (cancel)          a2 <= 1'b0;
            else if (op.wr_cmd)  a2 <= 1'b1;
            else if (op.wr_data) a2 <= 1'b0;
        end
    end

    // R11: abort always lands in idle with a pulse
    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (rst)
        cancel |=> (phase == PH_IDLE) && req_abort);

    // R6: end command cannot leave receive while a byte is held
    assert_end_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RECV && ibf && !cancel) |=> (phase == PH_RECV) && !req_end);

    // R13: start command outside idle does not reopen receive
    assert_start_ignored_R13: assert property (@(posedge clk) disable iff (rst)
        (phase inside {PH_WAIT, PH_SEND, PH_TAIL} && op.wr_cmd && op.wdata == CODE_START)
        |=> phase != PH_RECV);

endmodule

// File: rtl/hci_inbuf.sv
module hci_inbuf
    import hci_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_data,
    input  byte_t wdata,
    input  logic  accept_en,
    input  logic  cancel,
    input  logic  req_ready,
    output logic  ibf,
    output logic  ovr,
    output logic  req_valid,
    output byte_t req_data
);

    logic take;
    logic fresh;

    always_comb begin
        req_valid = ibf;
        take      = ibf && req_ready;
        fresh     = wr_data && accept_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ibf      <= 1'b0;
            ovr      <= 1'b0;
            req_data <= '0;
        end else if (cancel) begin
            ibf <= 1'b0;
            ovr <= 1'b0;
        end else begin
            if (take) ibf <= 1'b0;
            if (fresh) begin
                if (ibf) begin
                    ovr <= 1'b1;
                end else begin
                    ibf      <= 1'b1;
                    req_data <= wdata;
                end
            end
        end
    end

    // R4: a write into a full buffer marks overrun
    assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (fresh && ibf && !cancel) |=> ovr);

    // R4: the held byte survives until the backend takes it
    assert_hold_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (ibf && !req_ready && !cancel) |=> ibf && $stable(req_data));

    // R5: outside a request the buffer never fills
    assert_ignore_outside_R5: assert property (@(posedge clk) disable iff (rst)
        (!accept_en && !ibf) |=> !ibf);

endmodule

// File: rtl/hci_outbuf.sv
module hci_outbuf
    import hci_pkg::*;
#(
    parameter int MIN_RSP_BYTES = 6
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  logic   rd_data,
    input  logic   cancel,
    input  logic   rsp_valid,
    input  byte_t  rsp_data,
    input  logic   rsp_last,
    output logic   obf,
    output logic   f0,
    output byte_t  obuf,
    output logic   rsp_ready,
    output logic   tail_set
);

    localparam int CNT_W = $clog2(MIN_RSP_BYTES + 1);
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_RSP_BYTES);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic             last_seen;
    logic             slot_free;
    logic             head_load;
    logic             pay_load;
    logic             pad_load;

    always_comb begin
        head_load = (phase == PH_WAIT) && rsp_valid && !cancel;
        slot_free = (phase == PH_SEND) && !obf && !cancel;
        rsp_ready = slot_free && !last_seen;
        pay_load  = rsp_ready && rsp_valid;
        pad_load  = slot_free && last_seen && (cnt < MIN_CNT);
        tail_set  = slot_free && last_seen && (cnt >= MIN_CNT);
        cnt_inc   = (cnt >= MIN_CNT) ? cnt : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            obf       <= 1'b0;
            f0        <= 1'b0;
            obuf      <= '0;
            cnt       <= '0;
            last_seen <= 1'b0;
        end else if (cancel) begin
            obf       <= 1'b0;
            f0        <= 1'b0;
            cnt       <= '0;
            last_seen <= 1'b0;
        end else begin
            if (rd_data && obf) begin
                obf <= 1'b0;
                f0  <= 1'b0;
            end
            if (head_load) begin
                obuf      <= MARK_HEAD;
                obf       <= 1'b1;
                f0        <= 1'b1;
                cnt       <= '0;
                last_seen <= 1'b0;
            end else if (pay_load) begin
                obuf      <= rsp_data;
                obf       <= 1'b1;
                f0        <= 1'b0;
                cnt       <= cnt_inc;
                last_seen <= rsp_last;
            end else if (pad_load) begin
                obuf <= PAD_BYTE;
                obf  <= 1'b1;
                f0   <= 1'b0;
                cnt  <= cnt_inc;
            end else if (tail_set) begin
                obuf <= MARK_TAIL;
                obf  <= 1'b1;
                f0   <= 1'b1;
            end
        end
    end

    // R8: a full output buffer stays put until the host reads it
    assert_obf_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (obf && !rd_data && !cancel) |=> obf && $stable(obuf));

    // R8: a host read empties the buffer and drops the marker flag
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (obf && rd_data && !cancel) |=> !obf && !f0);

    // R11: nothing is taken from the backend in an abort cycle
    assert_no_take_abort_R11: assert property (@(posedge clk) disable iff (rst)
        cancel |-> !rsp_ready);

endmodule

// File: rtl/hci_host_port.sv
module hci_host_port
    import hci_pkg::*;
#(
    parameter int MIN_RSP_BYTES = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       req_valid,
    input  logic       req_ready,
    output logic [7:0] req_data,
    output logic       req_end,
    output logic       req_abort,
    input  logic       rsp_valid,
    output logic       rsp_ready,
    input  logic [7:0] rsp_data,
    input  logic       rsp_last
);

    host_op_t op;
    status_t  st;
    phase_e   phase;
    logic     a2, cancel, ibf, ovr, obf, f0, tail_set;
    byte_t    obuf;

    always_comb begin
        op.wr_cmd  = host_wr && host_addr;
        op.wr_data = host_wr && !host_addr;
        op.rd_data = host_rd && !host_addr;
        op.wdata   = host_wdata;
    end

    hci_phase_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .ibf       (ibf),
        .obf       (obf),
        .rsp_valid (rsp_valid),
        .tail_set  (tail_set),
        .phase     (phase),
        .a2        (a2),
        .cancel    (cancel),
        .req_end   (req_end),
        .req_abort (req_abort)
    );

    hci_inbuf inbuf_i (
        .clk       (clk),
        .rst       (rst),
        .wr_data   (op.wr_data),
        .wdata     (op.wdata),
        .accept_en (phase == PH_RECV),
        .cancel    (cancel),
        .req_ready (req_ready),
        .ibf       (ibf),
        .ovr       (ovr),
        .req_valid (req_valid),
        .req_data  (req_data)
    );

    hci_outbuf #(.MIN_RSP_BYTES(MIN_RSP_BYTES)) outbuf_i (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .rd_data   (op.rd_data),
        .cancel    (cancel),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last),
        .obf       (obf),
        .f0        (f0),
        .obuf      (obuf),
        .rsp_ready (rsp_ready),
        .tail_set  (tail_set)
    );

    always_comb begin
        st.obf  = obf;
        st.ibf  = ibf;
        st.f0   = f0;
        st.a2   = a2;
        st.rdy  = (phase == PH_IDLE);
        st.ibr  = (phase == PH_RECV);
        st.rsvd = 1'b0;
        st.ovr  = ovr;
        host_rdata = host_addr ? st : obuf;
    end

    // R11: an abort write leaves status at exactly ready
    assert_abort_status_R11: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr && host_wdata == CODE_ABORT) |=> st == 8'h10);

    // R2: start from ready flips to ready-for-data
    assert_start_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (st.rdy && host_wr && host_addr && host_wdata == CODE_START) |=> st.ibr && !st.rdy);

    // R12: a data write clears the command-address bit
    assert_a2_data_R12: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_addr) |=> !st.a2);

endmodule

// File: tb/hci_host_port_tb_top.sv
`timescale 1ns/1ps
module hci_host_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b1;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       req_valid, req_end, req_abort, rsp_ready;
    logic       req_ready = 1'b0;
    logic [7:0] req_data;
    logic       rsp_valid = 1'b0, rsp_last = 1'b0;
    logic [7:0] rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    hci_host_port dut_i (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .req_end(req_end), .req_abort(req_abort),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_last(rsp_last)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic peek(output logic [7:0] v);
        host_addr = 1'b1;
        #0.2;
        v = host_rdata;
    endtask

    task automatic hwr(input logic a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(output logic [7:0] v);
        host_addr = 1'b0; host_rd = 1'b1;
        #0.2;
        v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int rq, input int k);
        return 8'((k * 37) + (rq * 11) + 5);
    endfunction

    task automatic backend(input int rq, input int rn);
        for (int k = 0; k < rn; k++) begin
            rsp_valid = 1'b1;
            rsp_data  = pat(rq, k);
            rsp_last  = (k == rn - 1);
            for (int t = 0; t < 200; t++) begin
                #0.5;
                if (rsp_ready) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        rsp_valid = 1'b0;
        rsp_last  = 1'b0;
    endtask

    task automatic collect(input int rq, input int rn);
        logic [7:0] s, v;
        int total;
        bit ok;
        bit mark;
        int exp_d;
        total = (rn > 6) ? rn : 6;
        for (int idx = 0; idx < total + 2; idx++) begin
            ok = 1'b0;
            for (int t = 0; t < 60; t++) begin
                peek(s);
                if (s[0]) begin ok = 1'b1; break; end
                @(negedge clk);
            end
            chk("R7 R8 output full seen", int'(ok), 1);
            mark = (idx == 0) || (idx == total + 1);
            if (idx == 0) begin
                chk("R7 head status", s, 8'h0D);
                exp_d = 8'h01;
            end else if (idx == total + 1) begin
                chk("R9 tail status", s, 8'h0D);
                exp_d = 8'h03;
            end else if (idx - 1 < rn) begin
                chk("R8 payload status", s, 8'h09);
                exp_d = pat(rq, idx - 1);
            end else begin
                chk("R10 pad status", s, 8'h09);
                exp_d = 8'h00;
            end
            hrd(v);
            chk(mark ? "R7 R9 marker byte" : "R8 R10 payload byte", v, exp_d);
            peek(s);
            chk("R8 read clears output full", int'(s[0]), 0);
        end
    endtask

    task automatic run_txn(input int rq, input int rn);
        logic [7:0] s, b;
        hwr(1'b1, 8'h01);
        peek(s);
        chk("R2 start opens data phase", s, 8'h28);
        for (int k = 0; k < rq; k++) begin
            b = 8'(8'hA0 + rq * 8 + k);
            hwr(1'b0, b);
            peek(s);
            chk("R3 R12 input full status", s, 8'h22);
            chk("R3 req_valid", int'(req_valid), 1);
            chk("R3 req_data", req_data, b);
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            peek(s);
            chk("R3 input full cleared", s, 8'h20);
        end
        hwr(1'b1, 8'h03);
        chk("R6 req_end pulse", int'(req_end), 1);
        peek(s);
        chk("R6 request closed status", s, 8'h08);
        fork
            backend(rq, rn);
            collect(rq, rn);
        join
        peek(s);
        chk("R9 back to ready", s, 8'h18);
        chk("R6 req_end single", int'(req_end), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        peek(s);
        chk("R1 reset status", s, 8'h10);
        chk("R1 req_valid idle", int'(req_valid), 0);
        chk("R1 rsp_ready idle", int'(rsp_ready), 0);

        hwr(1'b0, 8'h55);
        peek(s);
        chk("R5 data write in idle ignored", s, 8'h10);
        chk("R5 no req_valid", int'(req_valid), 0);

        hwr(1'b1, 8'h03);
        peek(s);
        chk("R13 end command in idle ignored", s, 8'h18);
        chk("R13 no req_end", int'(req_end), 0);
        hwr(1'b1, 8'h7E);
        peek(s);
        chk("R13 unknown code ignored", s, 8'h18);
        hwr(1'b0, 8'h11);
        peek(s);
        chk("R12 data write clears A2", s, 8'h10);

        for (int rq = 1; rq <= 3; rq++)
            for (int rn = 1; rn <= 8; rn++)
                run_txn(rq, rn);

        // overrun and blocked end
        hwr(1'b1, 8'h01);
        hwr(1'b0, 8'hA1);
        hwr(1'b0, 8'hB2);
        peek(s);
        chk("R4 overrun status", s, 8'hA2);
        chk("R4 held byte kept", req_data, 8'hA1);
        hwr(1'b1, 8'h03);
        chk("R6 end blocked no pulse", int'(req_end), 0);
        peek(s);
        chk("R6 end blocked while full", s, 8'hAA);
        hwr(1'b1, 8'h01);
        peek(s);
        chk("R13 start during request ignored", s, 8'hAA);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        peek(s);
        chk("R4 overrun sticky", s, 8'hA8);
        hwr(1'b1, 8'h22);
        chk("R11 abort pulse", int'(req_abort), 1);
        peek(s);
        chk("R11 abort clears overrun", s, 8'h10);
        @(negedge clk);
        chk("R11 abort pulse single", int'(req_abort), 0);

        // abort while waiting for the backend
        hwr(1'b1, 8'h01);
        hwr(1'b1, 8'h03);
        hwr(1'b1, 8'h22);
        peek(s);
        chk("R11 abort from wait", s, 8'h10);

        // abort in the middle of a response
        hwr(1'b1, 8'h01);
        hwr(1'b1, 8'h03);
        rsp_valid = 1'b1; rsp_data = 8'h99; rsp_last = 1'b0;
        @(negedge clk);
        peek(s);
        chk("R7 head on completion", s, 8'h0D);
        hrd(v);
        chk("R7 head byte", v, 8'h01);
        @(negedge clk);
        rsp_data = 8'h9A;
        peek(s);
        chk("R8 first payload status", s, 8'h09);
        hwr(1'b1, 8'h22);
        peek(s);
        chk("R11 abort mid response", s, 8'h10);
        chk("R11 nothing taken after abort", int'(rsp_ready), 0);
        rsp_valid = 1'b0;
        @(negedge clk);
        run_txn(2, 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule